// File: doc/BRIEF.md
# Interrupt Pin Service and End-of-Interrupt Logic

This block is the request side of an interrupt routing controller. A source reports the level of one input pin per cycle. The block applies that pin's polarity and updates a pending bit for the pin. It then decides whether the pin needs service. Edge-mode pins need service only when the pending bit rises. Level-mode pins need service only while their remote-IRR flag is clear. A request that cannot be serviced is reported on a coalesced strobe.

Pins that need service are delivered one at a time, lowest index first. Each delivery is a message with a valid/ready handshake. The message carries the destination, vector, destination mode, trigger mode and delivery mode taken from the routing entry supplied by a separate register block. One configurable pin is always sent in physical mode to a boot-processor ID.

An end-of-interrupt carrying a vector starts a scan. The scan visits one entry per clock and pulses an acknowledge for each entry whose vector matches. When the end-of-interrupt is of level type, the scan also clears remote-IRR on each matching entry and re-arms the entry if it is unmasked and its request is still pending.

Top module: `irq_pin_service`

## Requirements
- R1: The effective level of a request is `req_level` XOR the pin's polarity bit (`rt_pol`, 1 = active low). An active effective level sets the pin's pending bit. An inactive effective level clears it and raises no strobe.
- R2: For an edge-mode pin (`rt_trig` bit = 0), an active request needs service only if the pin's pending bit was clear. Otherwise `coal_valid` pulses with `coal_pin` set to the pin, in the cycle after the request, and no message results.
- R3: For a level-mode pin (`rt_trig` bit = 1), an active request needs service only while the pin's `remote_irr` bit is clear. Otherwise `coal_valid` pulses with that pin and no message results.
- R4: When a masked entry (`rt_mask` bit = 1) is serviced, its service need is discarded. No message is issued and its `remote_irr` bit stays clear.
- R5: A serviced, unmasked entry produces a message that copies the entry's destination, vector, destination mode (`msg_logical`, 1 = logical), trigger mode and delivery mode, with `msg_assert` = 1 and `msg_short` = 2'b00. When the message is issued for a level-mode entry, that entry's `remote_irr` bit is set.
- R6: A message for pin `FIXED_PIN` carries `boot_id` as its destination and physical mode (`msg_logical` = 0), whatever the entry holds.
- R7: An `eoi_valid` pulse accepted while the block is idle raises `eoi_busy` for exactly `NUM_PINS` cycles. The scan visits entries 0 upward, one per cycle. `eoi_ack` pulses the bit of each entry whose vector equals the end-of-interrupt vector. An `eoi_valid` pulse that arrives while `eoi_busy` is high is ignored.
- R8: For a level-type end-of-interrupt (`eoi_level` = 1), each matching entry has its `remote_irr` bit cleared. If the entry is unmasked and its pending bit is still set, a new message follows the scan.
- R9: For an edge-type end-of-interrupt (`eoi_level` = 0), the scan only acknowledges. The `remote_irr` bits are unchanged.
- R10: No new message is issued while `eoi_busy` is high. Requests that need service during the scan are held and delivered after it ends.
- R11: At most one message is outstanding at a time. While `msg_valid` is high and `msg_ready` is low, the message fields hold steady. When several pins need service, the lowest index is delivered first.
- R12: After reset, `msg_valid`, `eoi_busy`, `coal_valid` and every `remote_irr` and pending bit are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A pin level report is present this cycle |
| req_pin | input | $clog2(NUM_PINS) | Index of the reporting pin |
| req_level | input | 1 | Raw level of the reporting pin |
| rt_vector | input | NUM_PINS*VEC_W | Vector of each routing entry |
| rt_dest | input | NUM_PINS*DEST_W | Destination of each entry |
| rt_dlv | input | NUM_PINS*DLV_W | Delivery mode of each entry |
| rt_logical | input | NUM_PINS | Destination mode per entry, 1 = logical |
| rt_trig | input | NUM_PINS | Trigger mode per entry, 1 = level |
| rt_pol | input | NUM_PINS | Polarity per entry, 1 = active low |
| rt_mask | input | NUM_PINS | Mask per entry, 1 = masked |
| boot_id | input | DEST_W | Destination forced for the fixed pin |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_vector | input | VEC_W | Vector being retired |
| eoi_level | input | 1 | 1 = level-type end-of-interrupt |
| eoi_busy | output | 1 | Scan in progress |
| eoi_ack | output | NUM_PINS | Acknowledge pulse for a matching entry |
| msg_valid | output | 1 | Delivery message present |
| msg_ready | input | 1 | Receiver takes the message |
| msg_dest | output | DEST_W | Message destination |
| msg_vector | output | VEC_W | Message vector |
| msg_logical | output | 1 | Message destination mode, 1 = logical |
| msg_trig | output | 1 | Message trigger mode, 1 = level |
| msg_dlv | output | DLV_W | Message delivery mode |
| msg_assert | output | 1 | Level-asserted flag of the message |
| msg_short | output | 2 | Destination shorthand, always none |
| coal_valid | output | 1 | A request was coalesced |
| coal_pin | output | $clog2(NUM_PINS) | Pin of the coalesced request |
| remote_irr | output | NUM_PINS | Remote-IRR flag of each entry |

## Verification
The bench builds the block with four pins, 8-bit vectors and destinations, 3-bit delivery modes, and the fixed-pin override on pin 0. Four pins make a whole end-of-interrupt scan only four cycles long, so a single test can start a scan, inject requests and a second end-of-interrupt during it, and watch both held requests come out afterwards in index order. The small table also lets two entries share a vector, which exercises acknowledges for several pins in one scan.

// File: rtl/irq_svc_pkg.sv
package irq_svc_pkg;
   localparam logic TRIG_EDGE     = 1'b0;
   localparam logic TRIG_LEVEL    = 1'b1;
   localparam logic DEST_PHYSICAL = 1'b0;
   localparam logic [1:0] SHORT_NONE = 2'b00;
endpackage

// File: rtl/irq_req_unit.sv
module irq_req_unit
   import irq_svc_pkg::*;
#(
   parameter int NUM_PINS = 8,
   localparam int PIN_W = $clog2(NUM_PINS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   input  logic [PIN_W-1:0]    req_pin,
   input  logic                req_level,
   input  logic [NUM_PINS-1:0] rt_pol,
   input  logic [NUM_PINS-1:0] rt_trig,
   input  logic [NUM_PINS-1:0] rirr,
   output logic [NUM_PINS-1:0] pend,
   output logic [NUM_PINS-1:0] svc_set,
   output logic                coal_valid,
   output logic [PIN_W-1:0]    coal_pin
);
   localparam logic [NUM_PINS-1:0] ONE = NUM_PINS'(1);

   logic eff;
   logic coal_now;

   // effective level after polarity
   assign eff = req_level ^ rt_pol[req_pin];

   always_comb begin
      svc_set  = '0;
      coal_now = 1'b0;
      if (req_valid && eff) begin
         if (rt_trig[req_pin] == TRIG_LEVEL) begin
            if (!rirr[req_pin]) svc_set = ONE << req_pin;
            else                coal_now = 1'b1;
         end else begin
            if (!pend[req_pin]) svc_set = ONE << req_pin;
            else                coal_now = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend       <= '0;
         coal_valid <= 1'b0;
         coal_pin   <= '0;
      end else begin
         if (req_valid) pend[req_pin] <= eff;
         coal_valid <= coal_now;
         coal_pin   <= req_pin;
      end
   end
endmodule

// File: rtl/irq_eoi_scan.sv
module irq_eoi_scan
   import irq_svc_pkg::*;
#(
   parameter int NUM_PINS = 8,
   parameter int VEC_W    = 8,
   localparam int PIN_W = $clog2(NUM_PINS)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      eoi_valid,
   input  logic [VEC_W-1:0]          eoi_vector,
   input  logic                      eoi_level,
   input  logic [NUM_PINS*VEC_W-1:0] rt_vector,
   input  logic [NUM_PINS-1:0]       rt_mask,
   input  logic [NUM_PINS-1:0]       pend,
   output logic                      busy,
   output logic [NUM_PINS-1:0]       ack,
   output logic [NUM_PINS-1:0]       rirr_clr,
   output logic [NUM_PINS-1:0]       svc_set
);
   localparam logic [NUM_PINS-1:0] ONE  = NUM_PINS'(1);
   localparam logic [PIN_W-1:0]    LAST = PIN_W'(NUM_PINS - 1);

   logic [PIN_W-1:0] idx_q;
   logic [VEC_W-1:0] vec_q;
   logic             lvl_q;
   logic             hit;
   logic [NUM_PINS-1:0] sel;

   assign sel = ONE << idx_q;
   assign hit = busy && (rt_vector[idx_q*VEC_W +: VEC_W] == vec_q);

   always_comb begin
      ack      = hit ? sel : '0;
      rirr_clr = (hit && lvl_q == TRIG_LEVEL) ? sel : '0;
      svc_set  = (hit && lvl_q == TRIG_LEVEL && !rt_mask[idx_q] && pend[idx_q]) ? sel : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         idx_q <= '0;
         vec_q <= '0;
         lvl_q <= 1'b0;
      end else if (!busy) begin
         if (eoi_valid) begin
            busy  <= 1'b1;
            idx_q <= '0;
            vec_q <= eoi_vector;
            lvl_q <= eoi_level;
         end
      end else begin
         if (idx_q == LAST) busy <= 1'b0;
         idx_q <= idx_q + 1'b1;
      end
   end
endmodule

// File: rtl/irq_msg_arb.sv
module irq_msg_arb
   import irq_svc_pkg::*;
#(
   parameter int NUM_PINS  = 8,
   parameter int VEC_W     = 8,
   parameter int DEST_W    = 8,
   parameter int DLV_W     = 3,
   parameter bit FIXED_EN  = 1'b1,
   parameter int FIXED_PIN = 0,
   localparam int PIN_W = $clog2(NUM_PINS)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NUM_PINS-1:0]        svc_pend,
   input  logic                       stall,
   input  logic [NUM_PINS*VEC_W-1:0]  rt_vector,
   input  logic [NUM_PINS*DEST_W-1:0] rt_dest,
   input  logic [NUM_PINS*DLV_W-1:0]  rt_dlv,
   input  logic [NUM_PINS-1:0]        rt_logical,
   input  logic [NUM_PINS-1:0]        rt_trig,
   input  logic [NUM_PINS-1:0]        rt_mask,
   input  logic [DEST_W-1:0]          boot_id,
   input  logic                       msg_ready,
   output logic [NUM_PINS-1:0]        svc_clr,
   output logic [NUM_PINS-1:0]        rirr_set,
   output logic                       msg_valid,
   output logic [DEST_W-1:0]          msg_dest,
   output logic [VEC_W-1:0]           msg_vector,
   output logic                       msg_logical,
   output logic                       msg_trig,
   output logic [DLV_W-1:0]           msg_dlv
);
   localparam logic [NUM_PINS-1:0] ONE = NUM_PINS'(1);

   logic [PIN_W-1:0] pick;
   logic             go;
   logic             take;
   logic             forced;
   logic [DEST_W-1:0] dest_sel;
   logic              logical_sel;

   // lowest set index wins
   always_comb begin
      pick = '0;
      for (int i = NUM_PINS - 1; i >= 0; i--) begin
         if (svc_pend[i]) pick = PIN_W'(i);
      end
   end

   assign go   = (|svc_pend) && !stall && (!msg_valid || msg_ready);
   assign take = go && !rt_mask[pick];

   generate
      if (FIXED_EN) begin : g_fixed
         assign forced = (pick == PIN_W'(FIXED_PIN));
      end else begin : g_free
         assign forced = 1'b0;
      end
   endgenerate

   assign dest_sel    = forced ? boot_id : rt_dest[pick*DEST_W +: DEST_W];
   assign logical_sel = forced ? DEST_PHYSICAL : rt_logical[pick];

   always_comb begin
      svc_clr  = go ? (ONE << pick) : '0;
      rirr_set = (take && rt_trig[pick] == TRIG_LEVEL) ? (ONE << pick) : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         msg_valid   <= 1'b0;
         msg_dest    <= '0;
         msg_vector  <= '0;
         msg_logical <= 1'b0;
         msg_trig    <= 1'b0;
         msg_dlv     <= '0;
      end else if (take) begin
         msg_valid   <= 1'b1;
         msg_dest    <= dest_sel;
         msg_vector  <= rt_vector[pick*VEC_W +: VEC_W];
         msg_logical <= logical_sel;
         msg_trig    <= rt_trig[pick];
         msg_dlv     <= rt_dlv[pick*DLV_W +: DLV_W];
      end else if (msg_ready) begin
         msg_valid <= 1'b0;
      end
   end
endmodule

// File: rtl/irq_pin_service.sv
module irq_pin_service
   import irq_svc_pkg::*;
#(
   parameter int NUM_PINS  = 8,
   parameter int VEC_W     = 8,
   parameter int DEST_W    = 8,
   parameter int DLV_W     = 3,
   parameter bit FIXED_EN  = 1'b1,
   parameter int FIXED_PIN = 0
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             req_valid,
   input  logic [$clog2(NUM_PINS)-1:0]      req_pin,
   input  logic                             req_level,
   input  logic [NUM_PINS*VEC_W-1:0]        rt_vector,
   input  logic [NUM_PINS*DEST_W-1:0]       rt_dest,
   input  logic [NUM_PINS*DLV_W-1:0]        rt_dlv,
   input  logic [NUM_PINS-1:0]              rt_logical,
   input  logic [NUM_PINS-1:0]              rt_trig,
   input  logic [NUM_PINS-1:0]              rt_pol,
   input  logic [NUM_PINS-1:0]              rt_mask,
   input  logic [DEST_W-1:0]                boot_id,
   input  logic                             eoi_valid,
   input  logic [VEC_W-1:0]                 eoi_vector,
   input  logic                             eoi_level,
   output logic                             eoi_busy,
   output logic [NUM_PINS-1:0]              eoi_ack,
   output logic                             msg_valid,
   input  logic                             msg_ready,
   output logic [DEST_W-1:0]                msg_dest,
   output logic [VEC_W-1:0]                 msg_vector,
   output logic                             msg_logical,
   output logic                             msg_trig,
   output logic [DLV_W-1:0]                 msg_dlv,
   output logic                             msg_assert,
   output logic [1:0]                       msg_short,
   output logic                             coal_valid,
   output logic [$clog2(NUM_PINS)-1:0]      coal_pin,
   output logic [NUM_PINS-1:0]              remote_irr
);
   generate
      if (NUM_PINS < 2 || NUM_PINS > 64 || (NUM_PINS & (NUM_PINS - 1)) != 0) begin : g_bad_pins
         $error("NUM_PINS must be a power of two between 2 and 64");
      end
      if (FIXED_PIN < 0 || FIXED_PIN >= NUM_PINS) begin : g_bad_fixed
         $error("FIXED_PIN outside the pin range");
      end
      if (VEC_W < 1 || DEST_W < 1 || DLV_W < 1) begin : g_bad_width
         $error("field widths must be positive");
      end
   endgenerate

   logic [NUM_PINS-1:0] pend;
   logic [NUM_PINS-1:0] svc_pend;
   logic [NUM_PINS-1:0] req_svc_set;
   logic [NUM_PINS-1:0] scan_svc_set;
   logic [NUM_PINS-1:0] scan_rirr_clr;
   logic [NUM_PINS-1:0] arb_svc_clr;
   logic [NUM_PINS-1:0] arb_rirr_set;

   irq_req_unit #(.NUM_PINS(NUM_PINS)) u_req (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_pin    (req_pin),
      .req_level  (req_level),
      .rt_pol     (rt_pol),
      .rt_trig    (rt_trig),
      .rirr       (remote_irr),
      .pend       (pend),
      .svc_set    (req_svc_set),
      .coal_valid (coal_valid),
      .coal_pin   (coal_pin)
   );

   irq_eoi_scan #(.NUM_PINS(NUM_PINS), .VEC_W(VEC_W)) u_scan (
      .clk        (clk),
      .rst_n      (rst_n),
      .eoi_valid  (eoi_valid),
      .eoi_vector (eoi_vector),
      .eoi_level  (eoi_level),
      .rt_vector  (rt_vector),
      .rt_mask    (rt_mask),
      .pend       (pend),
      .busy       (eoi_busy),
      .ack        (eoi_ack),
      .rirr_clr   (scan_rirr_clr),
      .svc_set    (scan_svc_set)
   );

   irq_msg_arb #(
      .NUM_PINS(NUM_PINS), .VEC_W(VEC_W), .DEST_W(DEST_W), .DLV_W(DLV_W),
      .FIXED_EN(FIXED_EN), .FIXED_PIN(FIXED_PIN)
   ) u_arb (
      .clk         (clk),
      .rst_n       (rst_n),
      .svc_pend    (svc_pend),
      .stall       (eoi_busy),
      .rt_vector   (rt_vector),
      .rt_dest     (rt_dest),
      .rt_dlv      (rt_dlv),
      .rt_logical  (rt_logical),
      .rt_trig     (rt_trig),
      .rt_mask     (rt_mask),
      .boot_id     (boot_id),
      .msg_ready   (msg_ready),
      .svc_clr     (arb_svc_clr),
      .rirr_set    (arb_rirr_set),
      .msg_valid   (msg_valid),
      .msg_dest    (msg_dest),
      .msg_vector  (msg_vector),
      .msg_logical (msg_logical),
      .msg_trig    (msg_trig),
      .msg_dlv     (msg_dlv)
   );

   assign msg_assert = 1'b1;
   assign msg_short  = SHORT_NONE;

   // new service needs win over the arbiter's clear in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         svc_pend   <= '0;
         remote_irr <= '0;
      end else begin
         svc_pend   <= (svc_pend & ~arb_svc_clr) | req_svc_set | scan_svc_set;
         remote_irr <= (remote_irr & ~scan_rirr_clr) | arb_rirr_set;
      end
   end
endmodule

// File: rtl/irq_pin_service_chk.sv
module irq_pin_service_chk #(
   parameter int NUM_PINS = 8,
   parameter int VEC_W    = 8,
   parameter int DEST_W   = 8
) (
   input logic                clk,
   input logic                rst_n,
   input logic                msg_valid,
   input logic                msg_ready,
   input logic [VEC_W-1:0]    msg_vector,
   input logic [DEST_W-1:0]   msg_dest,
   input logic                eoi_busy,
   input logic [NUM_PINS-1:0] eoi_ack,
   input logic [NUM_PINS-1:0] remote_irr
);
   a_r11_msg_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_vector) && $stable(msg_dest)));

   a_r10_no_issue_in_scan: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi_busy && !msg_valid) |=> !msg_valid);

   a_r7_ack_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(eoi_ack));

   a_r7_ack_in_scan: assert property (@(posedge clk) disable iff (!rst_n)
      !eoi_busy |-> (eoi_ack == '0));

   a_r8_rirr_clear_in_scan: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(remote_irr) & ~remote_irr) != '0) |-> $past(eoi_busy));

   a_r5_rirr_set_with_msg: assert property (@(posedge clk) disable iff (!rst_n)
      ((remote_irr & ~$past(remote_irr)) != '0) |-> msg_valid);
endmodule

bind irq_pin_service irq_pin_service_chk #(
   .NUM_PINS(NUM_PINS), .VEC_W(VEC_W), .DEST_W(DEST_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .msg_valid  (msg_valid),
   .msg_ready  (msg_ready),
   .msg_vector (msg_vector),
   .msg_dest   (msg_dest),
   .eoi_busy   (eoi_busy),
   .eoi_ack    (eoi_ack),
   .remote_irr (remote_irr)
);

// File: tb/irq_pin_service_bench.sv
module irq_pin_service_bench;
   localparam int CLK_PERIOD = 10;
   localparam int NP = 4;
   localparam int PW = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0;
   logic [PW-1:0] req_pin = '0;
   logic req_level = 1'b0;
   logic [NP*8-1:0] rt_vector = '0;
   logic [NP*8-1:0] rt_dest = '0;
   logic [NP*3-1:0] rt_dlv = '0;
   logic [NP-1:0] rt_logical = '0, rt_trig = '0, rt_pol = '0, rt_mask = '0;
   logic [7:0] boot_id = 8'h0A;
   logic eoi_valid = 1'b0;
   logic [7:0] eoi_vector = '0;
   logic eoi_level = 1'b0;
   logic eoi_busy;
   logic [NP-1:0] eoi_ack;
   logic msg_valid;
   logic msg_ready = 1'b0;
   logic [7:0] msg_dest, msg_vector;
   logic msg_logical, msg_trig, msg_assert;
   logic [2:0] msg_dlv;
   logic [1:0] msg_short;
   logic coal_valid;
   logic [PW-1:0] coal_pin;
   logic [NP-1:0] remote_irr;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   irq_pin_service #(.NUM_PINS(NP), .VEC_W(8), .DEST_W(8), .DLV_W(3),
                     .FIXED_EN(1'b1), .FIXED_PIN(0)) u_irq_pin_service (.*);

   task automatic chk(input string tag, input string what, input longint act, input longint exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic set_entry(input int p, input logic [7:0] vec, input logic [7:0] dst,
                            input logic [2:0] dl, input logic lg, input logic tr,
                            input logic pl, input logic mk);
      rt_vector[p*8 +: 8] = vec;
      rt_dest[p*8 +: 8]   = dst;
      rt_dlv[p*3 +: 3]    = dl;
      rt_logical[p]       = lg;
      rt_trig[p]          = tr;
      rt_pol[p]           = pl;
      rt_mask[p]          = mk;
   endtask

   task automatic do_req(input int p, input logic lvl, output logic cv, output logic [PW-1:0] cp);
      @(negedge clk);
      req_valid = 1'b1; req_pin = PW'(p); req_level = lvl;
      @(negedge clk);
      req_valid = 1'b0;
      cv = coal_valid; cp = coal_pin;
   endtask

   task automatic pop(output logic got, output logic [7:0] vec, output logic [7:0] dst,
                      output logic lg, output logic tr, output logic [2:0] dl,
                      output logic as, output logic [1:0] sh);
      got = 1'b0;
      for (int k = 0; k < 12 && !got; k++) begin
         if (msg_valid) got = 1'b1;
         else @(negedge clk);
      end
      vec = msg_vector; dst = msg_dest; lg = msg_logical; tr = msg_trig;
      dl = msg_dlv; as = msg_assert; sh = msg_short;
      if (got) begin
         msg_ready = 1'b1;
         @(negedge clk);
         msg_ready = 1'b0;
      end
   endtask

   task automatic no_msg(input string tag, input int cycles);
      logic seen = 1'b0;
      for (int k = 0; k < cycles; k++) begin
         @(negedge clk);
         if (msg_valid) seen = 1'b1;
      end
      chk(tag, "unexpected message", seen, 0);
   endtask

   task automatic do_eoi(input logic [7:0] vec, input logic lvl, output logic [NP-1:0] acks,
                         output int busy_cycles);
      acks = '0; busy_cycles = 0;
      @(negedge clk);
      eoi_valid = 1'b1; eoi_vector = vec; eoi_level = lvl;
      @(negedge clk);
      eoi_valid = 1'b0;
      for (int k = 0; k < NP + 2; k++) begin
         if (eoi_busy) begin
            busy_cycles++;
            acks = acks | eoi_ack;
         end
         @(negedge clk);
      end
   endtask

   // R12: reset state
   task automatic t_reset();
      chk("R12", "msg_valid", msg_valid, 0);
      chk("R12", "eoi_busy", eoi_busy, 0);
      chk("R12", "coal_valid", coal_valid, 0);
      chk("R12", "remote_irr", remote_irr, 0);
   endtask

   // R2, R5: edge pin delivery, fields and coalescing
   task automatic t_edge();
      logic cv, got, lg, tr, as; logic [PW-1:0] cp; logic [7:0] v, d; logic [2:0] dl; logic [1:0] sh;
      do_req(2, 1'b1, cv, cp);
      chk("R2", "first edge coalesced", cv, 0);
      pop(got, v, d, lg, tr, dl, as, sh);
      chk("R2", "edge delivered", got, 1);
      chk("R5", "vector", v, 8'h32);
      chk("R5", "dest", d, 8'h17);
      chk("R5", "logical", lg, 1);
      chk("R5", "trig", tr, 0);
      chk("R5", "dlv", dl, 3'd1);
      chk("R5", "assert", as, 1);
      chk("R5", "shorthand", sh, 0);
      do_req(2, 1'b1, cv, cp);
      chk("R2", "repeat coalesced", cv, 1);
      chk("R2", "coal pin", cp, 2);
      no_msg("R2", 5);
      do_req(2, 1'b0, cv, cp);
      chk("R2", "falling no strobe", cv, 0);
      do_req(2, 1'b1, cv, cp);
      pop(got, v, d, lg, tr, dl, as, sh);
      chk("R2", "re-edge delivered", got, 1);
      chk("R2", "re-edge vector", v, 8'h32);
   endtask

   // R1: polarity inversion
   task automatic t_polarity();
      logic cv, got, lg, tr, as; logic [PW-1:0] cp; logic [7:0] v, d; logic [2:0] dl; logic [1:0] sh;
      do_req(3, 1'b1, cv, cp);
      chk("R1", "inactive-low high coal", cv, 0);
      no_msg("R1", 4);
      do_req(3, 1'b0, cv, cp);
      pop(got, v, d, lg, tr, dl, as, sh);
      chk("R1", "active-low delivers", got, 1);
      chk("R1", "vector", v, 8'h33);
      do_req(3, 1'b0, cv, cp);
      chk("R1", "pending held coalesces", cv, 1);
      do_req(3, 1'b1, cv, cp);
   endtask

   // R4: masked level entry
   task automatic t_mask();
      logic cv; logic [PW-1:0] cp;
      set_entry(1, 8'h41, 8'h21, 3'd0, 1'b0, 1'b1, 1'b0, 1'b1);
      do_req(1, 1'b1, cv, cp);
      chk("R4", "masked not coalesced", cv, 0);
      no_msg("R4", 6);
      chk("R4", "remote_irr stays clear", remote_irr[1], 0);
      do_req(1, 1'b0, cv, cp);
      rt_mask[1] = 1'b0;
   endtask

   // R3, R5, R7, R8, R9: level pin and end-of-interrupt
   task automatic t_level_eoi();
      logic cv, got, lg, tr, as; logic [PW-1:0] cp; logic [7:0] v, d; logic [2:0] dl; logic [1:0] sh;
      logic [NP-1:0] acks; int bc;
      do_req(1, 1'b1, cv, cp);
      chk("R3", "first level coalesced", cv, 0);
      pop(got, v, d, lg, tr, dl, as, sh);
      chk("R3", "level delivered", got, 1);
      chk("R5", "level trig field", tr, 1);
      chk("R5", "remote_irr set", remote_irr[1], 1);
      do_req(1, 1'b1, cv, cp);
      chk("R3", "blocked coalesced", cv, 1);
      chk("R3", "coal pin", cp, 1);
      no_msg("R3", 4);
      do_eoi(8'h41, 1'b1, acks, bc);
      chk("R7", "ack mask", acks, 4'b0010);
      chk("R7", "busy cycles", bc, NP);
      pop(got, v, d, lg, tr, dl, as, sh);
      chk("R8", "re-delivered", got, 1);
      chk("R8", "re-delivered vector", v, 8'h41);
      chk("R8", "remote_irr set again", remote_irr[1], 1);
      do_req(1, 1'b0, cv, cp);
      do_eoi(8'h41, 1'b0, acks, bc);
      chk("R9", "edge eoi ack", acks, 4'b0010);
      chk("R9", "remote_irr unchanged", remote_irr[1], 1);
      no_msg("R9", 3);
      rt_vector[3*8 +: 8] = 8'h41;
      do_eoi(8'h41, 1'b1, acks, bc);
      chk("R7", "shared vector acks", acks, 4'b1010);
      chk("R8", "remote_irr cleared", remote_irr[1], 0);
      no_msg("R8", 6);
      rt_vector[3*8 +: 8] = 8'h33;
   endtask

   // R6: fixed pin override
   task automatic t_fixed();
      logic cv, got, lg, tr, as; logic [PW-1:0] cp; logic [7:0] v, d; logic [2:0] dl; logic [1:0] sh;
      do_req(0, 1'b1, cv, cp);
      pop(got, v, d, lg, tr, dl, as, sh);
      chk("R6", "delivered", got, 1);
      chk("R6", "boot dest", d, 8'h0A);
      chk("R6", "physical", lg, 0);
      chk("R6", "vector", v, 8'h30);
      chk("R6", "dlv", dl, 3'd2);
      do_req(0, 1'b0, cv, cp);
   endtask

   // R7, R10, R11: requests held through a scan, ordered by index
   task automatic t_scan_hold();
      logic cv, got, lg, tr, as; logic [PW-1:0] cp; logic [7:0] v, d, v0; logic [2:0] dl; logic [1:0] sh;
      logic [NP-1:0] acks = '0; logic seen = 1'b0;
      do_req(2, 1'b0, cv, cp);
      @(negedge clk);
      eoi_valid = 1'b1; eoi_vector = 8'hEE; eoi_level = 1'b1;
      @(negedge clk);
      chk("R7", "busy raised", eoi_busy, 1);
      req_valid = 1'b1; req_pin = 2'd3; req_level = 1'b0;
      eoi_valid = 1'b1; eoi_vector = 8'h30;
      acks = acks | eoi_ack;
      @(negedge clk);
      req_pin = 2'd2; req_level = 1'b1; eoi_valid = 1'b0;
      acks = acks | eoi_ack; if (msg_valid) seen = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      acks = acks | eoi_ack; if (msg_valid) seen = 1'b1;
      @(negedge clk);
      acks = acks | eoi_ack; if (msg_valid) seen = 1'b1;
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         acks = acks | eoi_ack;
      end
      chk("R10", "no message during scan", seen, 0);
      chk("R7", "second eoi ignored", acks, 0);
      chk("R7", "scan ended", eoi_busy, 0);
      for (int k = 0; k < 8 && !msg_valid; k++) @(negedge clk);
      v0 = msg_vector;
      @(negedge clk); @(negedge clk);
      chk("R11", "held valid", msg_valid, 1);
      chk("R11", "held vector", msg_vector, v0);
      pop(got, v, d, lg, tr, dl, as, sh);
      chk("R11", "lowest first", v, 8'h32);
      pop(got, v, d, lg, tr, dl, as, sh);
      chk("R10", "held request delivered", got, 1);
      chk("R11", "second vector", v, 8'h33);
      no_msg("R11", 3);
   endtask

   initial begin
      set_entry(0, 8'h30, 8'h55, 3'd2, 1'b1, 1'b0, 1'b0, 1'b0);
      set_entry(1, 8'h41, 8'h21, 3'd0, 1'b0, 1'b1, 1'b0, 1'b0);
      set_entry(2, 8'h32, 8'h17, 3'd1, 1'b1, 1'b0, 1'b0, 1'b0);
      set_entry(3, 8'h33, 8'h13, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_edge();
      t_polarity();
      t_mask();
      t_level_eoi();
      t_fixed();
      t_scan_hold();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule